// File: doc/BRIEF.md
# Guard-Bit Streaming Sum Accumulator

This block adds up a stream of signed two's-complement words, one word per valid cycle, and at the end of the stream reports whether the exact total fits back into a single signed word. Every incoming word is sign-extended into a wider accumulator. The accumulator carries enough extra high bits that the largest allowed number of words can never wrap it. Running totals are therefore free to pass outside the word range while the stream is in progress. Only the final total is judged.

A stream opens with a one-cycle start pulse, which clears the accumulator, the element counter and the previous result. Words then arrive on a valid/data/last interface. The stream closes either on a beat marked last, or on a flush pulse, which closes it with or without a word in that cycle. One cycle after the closing beat the block raises a single-cycle done pulse. At the same time it presents the low word of the total and an overflow flag. When the total is out of range, the result port shows zero. Beats beyond the configured maximum count are dropped and raise a sticky protocol error.

Top module: `sum_guard_acc`

## Requirements
- R1: The accumulator holds W + ceil(log2 N) bits, so any stream of up to N words (for example N copies of the most positive or the most negative value) gives the exact total.
- R2: Each accepted word is read as signed two's-complement and sign-extended before it is added. A word with its top bit set counts as negative.
- R3: ovf_o is 1 exactly when the final total is below -2^(W-1) or above 2^(W-1)-1. Both end points of that range count as in range.
- R4: Running totals that leave the W-bit range part-way through a stream cause no error when the final total is in range (W=8: 120, 120, -115 gives 125 with ovf_o = 0).
- R5: When the total is in range, sum_o equals the low W bits of the total. When ovf_o is 1, sum_o is 0.
- R6: On the cycle after a start pulse, done_o, sum_o, ovf_o and err_o are all 0, and the next stream sums from zero.
- R7: done_o goes high for exactly one cycle, on the clock after the closing beat (last or flush) is taken.
- R8: sum_o and ovf_o keep their values from one done pulse until the next start pulse.
- R9: A flush pulse closes the open stream. A word presented in the same cycle is included. start followed directly by flush gives sum_o = 0 with ovf_o = 0.
- R10: Once N words have been taken, any further valid beat is dropped without touching the total, and it sets err_o. err_o stays 1 until the next start.
- R11: Valid beats while no stream is open are ignored. They change neither sum_o nor err_o, and they produce no done pulse.
- R12: After reset, done_o, sum_o, ovf_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new stream and clears all state |
| in_valid_i | input | 1 | A word is present on in_data_i |
| in_data_i | input | W | Signed input word |
| in_last_i | input | 1 | Marks the valid beat as the final word |
| flush_i | input | 1 | Closes the open stream |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| sum_o | output | W | Low word of the total, or 0 on overflow |
| ovf_o | output | 1 | Total lies outside the signed W-bit range |
| err_o | output | 1 | Sticky: a beat arrived after N words |

## Verification
The bench sends streams whose running totals leave the word range but return, and totals sitting exactly on -128 and 127 and one step beyond each. A design that checks each partial sum would flag the first kind. A range test that is off by one would misjudge the edges. Full-length streams of 127s and of -128s would wrap an accumulator with one guard bit too few, and it would report a wrong total. Over-count beats, idle beats and flush in both forms are also covered: a design that adds a dropped beat, forgets the sticky error, or mishandles an empty stream shows a wrong result, a stray done pulse or a wrong error flag.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sacc_state_e;

  // Number of guard bits needed for a maximum element count
  function automatic int guard_bits(input int max_count);
    return (max_count <= 1) ? 0 : $clog2(max_count);
  endfunction

endpackage

// File: rtl/sacc_ctl.sv
module sacc_ctl
  import sacc_pkg::*;
#(
  parameter int N     = 16,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  input  logic             flush_i,
  output logic             take_o,
  output logic             drop_o,
  output logic             end_o,
  output logic             err_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(N);

  sacc_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             room;

  assign room   = (cnt_q < CNT_MAX);
  assign take_o = (st_q == ST_RUN) && !start_i && in_valid_i && room;
  assign drop_o = (st_q == ST_RUN) && !start_i && in_valid_i && !room;
  assign end_o  = (st_q == ST_RUN) && !start_i &&
                  ((take_o && in_last_i) || flush_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (start_i) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (take_o) cnt_q <= cnt_q + 1'b1;
      if (drop_o) err_q <= 1'b1;
      if (end_o)  st_q  <= ST_IDLE;
    end
  end

  assign err_o = err_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/sacc_acc.sv
module sacc_acc #(
  parameter int W     = 8,
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [W-1:0]     data_i,
  output logic [ACC_W-1:0] total_o
);

  logic [ACC_W-1:0] acc_q;

  // Sign extension of one word to accumulator width
  function automatic logic [ACC_W-1:0] widen(input logic [W-1:0] d);
    logic signed [ACC_W-1:0] r;
    r = $signed(d);
    return r;
  endfunction

  // Total including the word taken this cycle
  assign total_o = acc_q + (add_i ? widen(data_i) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= total_o;
  end

endmodule

// File: rtl/sacc_fit.sv
module sacc_fit #(
  parameter int W     = 8,
  parameter int ACC_W = 12
) (
  input  logic [ACC_W-1:0] total_i,
  output logic             fits_o,
  output logic [W-1:0]     low_o
);

  assign low_o = total_i[W-1:0];

  generate
    if (ACC_W == W) begin : g_noguard
      assign fits_o = 1'b1;
    end else begin : g_guard
      // In range when all bits from W-1 upward copy the sign
      logic [ACC_W-W:0] top;
      assign top    = total_i[ACC_W-1:W-1];
      assign fits_o = (top == '0) || (top == '1);
    end
  endgenerate

endmodule

// File: rtl/sum_guard_acc.sv
module sum_guard_acc
  import sacc_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  input  logic         in_last_i,
  input  logic         flush_i,
  output logic         done_o,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         err_o
);

  localparam int ACC_W = W + guard_bits(N);
  localparam int CNT_W = $clog2(N + 1);

  logic             take_w;
  logic             drop_w;
  logic             end_w;
  logic [CNT_W-1:0] cnt_w;
  logic [ACC_W-1:0] total_w;
  logic             fits_w;
  logic [W-1:0]     low_w;

  logic             done_q;
  logic [W-1:0]     sum_q;
  logic             ovf_q;

  sacc_ctl #(.N(N), .CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .in_valid_i(in_valid_i),
    .in_last_i (in_last_i),
    .flush_i   (flush_i),
    .take_o    (take_w),
    .drop_o    (drop_w),
    .end_o     (end_w),
    .err_o     (err_o),
    .cnt_o     (cnt_w)
  );

  sacc_acc #(.W(W), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_i),
    .add_i  (take_w),
    .data_i (in_data_i),
    .total_o(total_w)
  );

  sacc_fit #(.W(W), .ACC_W(ACC_W)) u_fit (
    .total_i(total_w),
    .fits_o (fits_w),
    .low_o  (low_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      sum_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (start_i) begin
      done_q <= 1'b0;
      sum_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (end_w) begin
      done_q <= 1'b1;
      sum_q  <= fits_w ? low_w : '0;
      ovf_q  <= !fits_w;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign sum_o  = sum_q;
  assign ovf_o  = ovf_q;

endmodule

// File: rtl/sacc_chk.sv
module sacc_chk #(
  parameter int W     = 8,
  parameter int N     = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             in_valid_i,
  input logic             end_w,
  input logic             drop_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic             done_o,
  input logic [W-1:0]     sum_o,
  input logic             ovf_o,
  input logic             err_o
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_w && !start_i) |=> done_o);

  // R5
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (sum_o == '0));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !end_w) |=> ($stable(sum_o) && $stable(ovf_o)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);

  // R10
  drop_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w |=> err_o);

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= CNT_W'(N));

  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !ovf_o && !err_o && sum_o == '0));

endmodule

bind sum_guard_acc sacc_chk #(.W(W), .N(N), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .in_valid_i(in_valid_i),
  .end_w     (end_w),
  .drop_w    (drop_w),
  .cnt_w     (cnt_w),
  .done_o    (done_o),
  .sum_o     (sum_o),
  .ovf_o     (ovf_o),
  .err_o     (err_o)
);

// File: tb/sum_guard_acc_tb_top.sv
`timescale 1ns/1ps
module sum_guard_acc_tb_top;

  localparam int W = 8;
  localparam int N = 16;
  localparam int LO = -(1 << (W - 1));
  localparam int HI = (1 << (W - 1)) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [W-1:0] in_data_i = '0;
  logic         in_last_i = 1'b0;
  logic         flush_i = 1'b0;
  logic         done_o;
  logic [W-1:0] sum_o;
  logic         ovf_o;
  logic         err_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [W-1:0] sum;
    logic         ovf;
    string        tag;
  } exp_t;

  exp_t sb[$];
  int   stim[$];
  logic prev_done = 1'b0;

  always #2.5 clk = ~clk;

  sum_guard_acc #(.W(W), .N(N)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .in_valid_i(in_valid_i),
    .in_data_i (in_data_i),
    .in_last_i (in_last_i),
    .flush_i   (flush_i),
    .done_o    (done_o),
    .sum_o     (sum_o),
    .ovf_o     (ovf_o),
    .err_o     (err_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compare each done against the scoreboard head
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(!done_o, "R7 done longer than one cycle", done_o, 0);
      if (done_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11 done without an open stream", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(sum_o == e.sum, {e.tag, " sum"}, int'($signed(sum_o)), int'($signed(e.sum)));
          check(ovf_o == e.ovf, {e.tag, " ovf"}, ovf_o, e.ovf);
        end
      end
      prev_done = done_o;
    end
  end

  // Driver: runs stim[] as one stream; extra beats beyond N are sent before flush
  task automatic run_stream(input bit use_flush, input int extra, input string tag);
    int   t;
    exp_t e;
    t = 0;
    foreach (stim[i]) t += stim[i];
    e.ovf = (t < LO) || (t > HI);
    e.sum = e.ovf ? '0 : t[W-1:0];
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    foreach (stim[i]) begin
      in_valid_i = 1'b1;
      in_data_i  = stim[i][W-1:0];
      in_last_i  = !use_flush && (extra == 0) && (i == stim.size() - 1);
      @(negedge clk);
    end
    for (int k = 0; k < extra; k++) begin
      in_valid_i = 1'b1;
      in_data_i  = 8'd50;
      in_last_i  = 1'b0;
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
    if (use_flush) begin
      flush_i = 1'b1;
      @(negedge clk);
      flush_i = 1'b0;
    end
    repeat (3) @(negedge clk);
    stim.delete();
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(done_o == 0 && sum_o == 0 && ovf_o == 0 && err_o == 0, "R12 reset", int'(sum_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 partial sum leaves range, final fits
    stim = '{120, 120, -115};
    run_stream(1'b0, 0, "R4");
    // R8 held across idle cycles
    repeat (5) @(negedge clk);
    check(sum_o == 8'd125 && !ovf_o, "R8 hold", int'(sum_o), 125);

    // R11 idle beat ignored
    in_valid_i = 1'b1; in_data_i = 8'd77; in_last_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0; in_last_i = 1'b0;
    @(negedge clk);
    check(sum_o == 8'd125 && !err_o && !done_o, "R11 idle beat", int'(sum_o), 125);

    // R3 R5 positive overflow, result forced to zero
    stim = '{100, 100};
    run_stream(1'b0, 0, "R3 R5 positive");
    // R2 R3 negative overflow by one
    stim = '{-128, -1};
    run_stream(1'b0, 0, "R2 R3 below");
    // R3 edges
    stim = '{100, 27};
    run_stream(1'b0, 0, "R3 top edge");
    stim = '{-100, -28};
    run_stream(1'b0, 0, "R3 bottom edge");
    stim = '{100, 28};
    run_stream(1'b0, 0, "R3 top plus one");

    // R1 full-length extremes
    for (int i = 0; i < N; i++) stim.push_back(127);
    run_stream(1'b0, 0, "R1 max positive");
    for (int i = 0; i < N; i++) stim.push_back(-128);
    run_stream(1'b0, 0, "R1 max negative");
    for (int i = 0; i < N; i++) stim.push_back((i % 2 == 0) ? 127 : -128);
    run_stream(1'b0, 0, "R1 R4 alternating");

    // R9 empty stream and flush after words
    run_stream(1'b1, 0, "R9 empty");
    stim = '{5, 6};
    run_stream(1'b1, 0, "R9 flush");

    // R10 over-count beats dropped, sticky error
    for (int i = 0; i < N; i++) stim.push_back(1);
    run_stream(1'b1, 2, "R10 overcount");
    check(err_o == 1'b1, "R10 sticky error", err_o, 1);

    // R6 start clears result and error
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(!err_o && sum_o == 0 && !ovf_o && !done_o, "R6 start clear", int'(err_o), 0);
    flush_i = 1'b1;
    sb.push_back('{sum: '0, ovf: 1'b0, tag: "R6 R9 flush after clear"});
    @(negedge clk); flush_i = 1'b0;
    repeat (3) @(negedge clk);

    check(sb.size() == 0, "R7 all results seen", sb.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule